// File: doc/BRIEF.md
# Frequency-Domain FIR Filter Engine (Iterative Radix-2 FFT)

The engine takes a block of N = 2^LOG2N complex fixed-point samples over a valid/ready stream and writes them into a register bank at bit-reversed addresses. It then runs LOG2N decimation-in-time radix-2 stages, one stage per clock. All N/2 butterflies of a stage work at once and write their results back to the addresses they read. The stream then emits the filtered spectrum Y(k) = X(k)·H(k) in natural order, one bin per cycle. The complex product is formed on the fly from the transformed bank and a built-in response table.

A block opens with a start flag and closes either on its N-th sample or on an earlier sample marked last. In the second case the remaining positions hold zero. While the engine computes or emits, it refuses input, so blocks never overlap. Twiddle factors and the response H(k) are constants fixed at elaboration.

Top module: `fft_filt_engine`

## Requirements
- R1: After reset, in_ready_o is 1 and busy_o and out_valid_o are 0.
- R2: An accepted sample with in_sop_i = 1 opens a block and is sample 0. A sample accepted with in_sop_i = 0 while no block is open is ignored: busy_o and out_valid_o stay 0.
- R3: A block closes on its N-th accepted sample, or earlier on an accepted sample with in_last_i = 1. Sample positions that were not loaded count as 0 + j0.
- R4: The transform is a radix-2 DIT FFT. Sample i is stored at the bit-reversed address of i. Stage s (0-based) pairs addresses half = 2^s apart and uses the twiddle W(j·N/(2·half)), where j is the offset inside the group. W(k).re = round(32767·cos(2πk/N)) and W(k).im = −round(32767·sin(2πk/N)), with round meaning half away from zero. The twiddle product is t = (lo·W + 2^14) >>> 15 per component. The results are top = sat((hi + t + 1) >>> 1) and bottom = sat((hi − t + 1) >>> 1), where >>> is an arithmetic shift.
- R5: Let d = min(k, N−k). The response has H(k).re = 32767 − (2·32767·d) div N. H(k).im = −1024·k for k < N/2, and +1024·(N−k) otherwise. Each output is Y(k) = sat((X(k)·H(k) + 2^14) >>> 15) per component.
- R6: busy_o rises in the cycle after the closing sample. Exactly LOG2N cycles follow with out_valid_o = 0. Then out_valid_o stays high for N consecutive cycles, carrying Y(0)…Y(N−1).
- R7: out_last_o is 1 only with Y(N−1). In the next cycle in_ready_o is 1 and busy_o is 0.
- R8: in_ready_o is 0 whenever busy_o is 1. Input presented in that time has no effect on the outputs of the block being processed.
- R9: A sample with in_sop_i = 1 accepted while a block is open restarts the block. Earlier samples of that block are dropped.
- R10: sat() limits every butterfly result and output component to the range −32768…32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Engine accepts input |
| in_sop_i | input | 1 | Sample opens a new block |
| in_last_i | input | 1 | Sample closes the block early |
| in_re_i | input | 16 | Sample real part, signed |
| in_im_i | input | 16 | Sample imaginary part, signed |
| busy_o | output | 1 | Transform or output in progress |
| out_valid_o | output | 1 | Output bin valid |
| out_last_o | output | 1 | Output bin is Y(N−1) |
| out_re_o | output | 16 | Y(k) real part, signed |
| out_im_o | output | 16 | Y(k) imaginary part, signed |

## Verification
A fault in the butterfly addressing, the twiddle selection or the bit-reversed load appears only in the data bins. It shows up in the first output burst, at most LOG2N + N cycles after the closing sample, so every bin of every block is compared against an exact integer model. A stage or bin counter that is off by one shows as early or late out_valid_o or out_last_o within the same burst. A missing clear or a missing input gate shows in the very next block, through the short-block, restart and held-valid cases.

// File: rtl/fft_filt_pkg.sv
package fft_filt_pkg;
  localparam int DW = 16;
  localparam int PW = DW + 2;
  localparam int SW = DW + 4;
  localparam int FS = (1 << (DW - 1)) - 1;
  localparam real PI = 3.14159265358979323846;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cpx_t;

  localparam logic signed [SW-1:0] SAT_HI = SW'(FS);
  localparam logic signed [SW-1:0] SAT_LO = SW'(-FS - 1);

  function automatic logic signed [DW-1:0] sat_dw(input logic signed [SW-1:0] v);
    if (v > SAT_HI) return DW'(FS);
    if (v < SAT_LO) return DW'(-FS - 1);
    return v[DW-1:0];
  endfunction

  function automatic int unsigned bitrev(input int unsigned v, input int w);
    int unsigned r = 0;
    for (int i = 0; i < w; i++) r |= ((v >> i) & 1) << (w - 1 - i);
    return r;
  endfunction

  function automatic cpx_t tw_val(input int k, input int n);
    cpx_t c;
    real ang = 2.0 * PI * real'(k) / real'(n);
    c.re = DW'(int'(real'(FS) * $cos(ang)));
    c.im = DW'(-int'(real'(FS) * $sin(ang)));
    return c;
  endfunction

  function automatic cpx_t h_val(input int k, input int n);
    cpx_t c;
    int d = (k < n - k) ? k : n - k;
    c.re = DW'(FS - (2 * FS * d) / n);
    c.im = DW'((k < n / 2) ? -(k * 1024) : (n - k) * 1024);
    return c;
  endfunction
endpackage

// File: rtl/fft_cmul.sv
module fft_cmul
  import fft_filt_pkg::*;
(
  input  cpx_t                 a_i,
  input  cpx_t                 w_i,
  output logic signed [PW-1:0] re_o,
  output logic signed [PW-1:0] im_o
);
  localparam int MW = 2 * DW + 2;

  logic signed [MW-1:0] ar, ai, wr, wi, p_re, p_im;

  assign ar = MW'(a_i.re);
  assign ai = MW'(a_i.im);
  assign wr = MW'(w_i.re);
  assign wi = MW'(w_i.im);
  // Q15 product, round half up
  assign p_re = ar * wr - ai * wi + MW'(1 << (DW - 2));
  assign p_im = ar * wi + ai * wr + MW'(1 << (DW - 2));
  assign re_o = PW'(p_re >>> (DW - 1));
  assign im_o = PW'(p_im >>> (DW - 1));
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly
  import fft_filt_pkg::*;
(
  input  cpx_t hi_i,
  input  cpx_t lo_i,
  input  cpx_t w_i,
  output cpx_t top_o,
  output cpx_t bot_o
);
  logic signed [PW-1:0] t_re, t_im;

  fft_cmul u_mul (.a_i(lo_i), .w_i(w_i), .re_o(t_re), .im_o(t_im));

  function automatic logic signed [DW-1:0] half_sat(input logic signed [SW-1:0] v);
    return sat_dw((v + SW'(1)) >>> 1);
  endfunction

  assign top_o.re = half_sat(SW'(hi_i.re) + SW'(t_re));
  assign top_o.im = half_sat(SW'(hi_i.im) + SW'(t_im));
  assign bot_o.re = half_sat(SW'(hi_i.re) - SW'(t_re));
  assign bot_o.im = half_sat(SW'(hi_i.im) - SW'(t_im));
endmodule

// File: rtl/fft_coef_rom.sv
module fft_coef_rom
  import fft_filt_pkg::*;
#(
  parameter int LOG2N = 4
) (
  output cpx_t tw_o [2**(LOG2N-1)],
  output cpx_t h_o  [2**LOG2N]
);
  localparam int N = 2 ** LOG2N;

  for (genvar k = 0; k < N / 2; k++) begin : g_tw
    localparam cpx_t TWK = tw_val(k, N);
    assign tw_o[k] = TWK;
  end

  for (genvar k = 0; k < N; k++) begin : g_h
    localparam cpx_t HK = h_val(k, N);
    assign h_o[k] = HK;
  end
endmodule

// File: rtl/fft_filt_engine.sv
module fft_filt_engine
  import fft_filt_pkg::*;
#(
  parameter int LOG2N = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic                 in_sop_i,
  input  logic                 in_last_i,
  input  logic signed [DW-1:0] in_re_i,
  input  logic signed [DW-1:0] in_im_i,
  output logic                 busy_o,
  output logic                 out_valid_o,
  output logic                 out_last_o,
  output logic signed [DW-1:0] out_re_o,
  output logic signed [DW-1:0] out_im_o
);
  localparam int N   = 2 ** LOG2N;
  localparam int NH  = N / 2;
  localparam int TWW = LOG2N - 1;
  localparam int SCW = (LOG2N > 1) ? $clog2(LOG2N) : 1;

  typedef enum logic [1:0] {ST_LOAD, ST_CALC, ST_OUT} st_e;

  st_e              st_q;
  logic [SCW-1:0]   stg_q;
  logic [LOG2N-1:0] cnt_q;
  logic             open_q;
  cpx_t             mem_q [N];
  cpx_t             tw [NH];
  cpx_t             hk [N];

  fft_coef_rom #(.LOG2N(LOG2N)) u_rom (.tw_o(tw), .h_o(hk));

  // input acceptance
  logic             take, close;
  logic [LOG2N-1:0] cnt_w, wr_idx;

  assign take   = in_valid_i && (st_q == ST_LOAD) && (in_sop_i || open_q);
  assign cnt_w  = in_sop_i ? '0 : cnt_q;
  assign close  = take && (in_last_i || cnt_w == LOG2N'(N - 1));
  assign wr_idx = LOG2N'(bitrev(int'(cnt_w), LOG2N));

  // one row of butterflies, operands steered by the stage counter
  logic [LOG2N-1:0] a_top [NH];
  logic [LOG2N-1:0] a_bot [NH];
  cpx_t             bf_top [NH];
  cpx_t             bf_bot [NH];

  for (genvar b = 0; b < NH; b++) begin : g_bf
    localparam logic [LOG2N-1:0] BI = LOG2N'(b);
    logic [LOG2N-1:0] half, j, top_l;
    logic [TWW-1:0]   tw_sel;

    always_comb begin
      half   = LOG2N'(1) << stg_q;
      j      = BI & (half - LOG2N'(1));
      top_l  = ((BI >> stg_q) << (int'(stg_q) + 1)) | j;
      tw_sel = TWW'(j << (LOG2N - 1 - int'(stg_q)));
    end

    assign a_top[b] = top_l;
    assign a_bot[b] = top_l | half;

    fft_bfly u_bf (
      .hi_i (mem_q[a_top[b]]),
      .lo_i (mem_q[a_bot[b]]),
      .w_i  (tw[tw_sel]),
      .top_o(bf_top[b]),
      .bot_o(bf_bot[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
    end else if (st_q == ST_CALC) begin
      for (int b = 0; b < NH; b++) begin
        mem_q[a_top[b]] <= bf_top[b];
        mem_q[a_bot[b]] <= bf_bot[b];
      end
    end else if (take) begin
      if (in_sop_i) for (int i = 0; i < N; i++) mem_q[i] <= '0;
      mem_q[wr_idx] <= '{re: in_re_i, im: in_im_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_LOAD;
      stg_q  <= '0;
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      case (st_q)
        ST_LOAD: if (take) begin
          cnt_q  <= cnt_w + LOG2N'(1);
          open_q <= !close;
          if (close) begin
            st_q  <= ST_CALC;
            stg_q <= '0;
          end
        end
        ST_CALC: begin
          stg_q <= stg_q + SCW'(1);
          if (int'(stg_q) == LOG2N - 1) begin
            st_q  <= ST_OUT;
            cnt_q <= '0;
          end
        end
        ST_OUT: begin
          cnt_q <= cnt_q + LOG2N'(1);
          if (cnt_q == LOG2N'(N - 1)) st_q <= ST_LOAD;
        end
        default: st_q <= ST_LOAD;
      endcase
    end
  end

  // frequency-domain multiply on the read path
  logic signed [PW-1:0] y_re, y_im;

  fft_cmul u_filt (.a_i(mem_q[cnt_q]), .w_i(hk[cnt_q]), .re_o(y_re), .im_o(y_im));

  assign in_ready_o  = (st_q == ST_LOAD);
  assign busy_o      = (st_q != ST_LOAD);
  assign out_valid_o = (st_q == ST_OUT);
  assign out_last_o  = out_valid_o && (cnt_q == LOG2N'(N - 1));
  assign out_re_o    = sat_dw(SW'(y_re));
  assign out_im_o    = sat_dw(SW'(y_im));
endmodule

// File: rtl/fft_filt_chk.sv
module fft_filt_chk #(
  parameter int LOG2N = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_ready_o,
  input logic busy_o,
  input logic out_valid_o,
  input logic out_last_o
);
  localparam int N  = 2 ** LOG2N;
  localparam int BW = LOG2N + 1;

  logic [7:0]    lat_q;
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= '0;
      beat_q <= '0;
    end else begin
      lat_q  <= (busy_o && !out_valid_o) ? lat_q + 8'd1 : 8'd0;
      if (out_last_o)       beat_q <= '0;
      else if (out_valid_o) beat_q <= beat_q + BW'(1);
    end
  end

  // R6
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (lat_q == 8'(LOG2N)));

  // R6
  burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> out_valid_o);

  // R7
  last_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> (beat_q == BW'(N - 1)));

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |=> (in_ready_o && !busy_o && !out_valid_o));
endmodule

bind fft_filt_engine fft_filt_chk #(.LOG2N(LOG2N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .busy_o     (busy_o),
  .out_valid_o(out_valid_o),
  .out_last_o (out_last_o)
);

// File: tb/sim_fft_filt_engine.sv
`timescale 1ns/1ps
module sim_fft_filt_engine;
  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_last = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic in_ready, busy, out_valid, out_last;
  logic signed [15:0] out_re, out_im;

  always #5 clk = ~clk;

  fft_filt_engine #(.LOG2N(LOG2N)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_sop_i(in_sop), .in_last_i(in_last),
    .in_re_i(in_re), .in_im_i(in_im),
    .busy_o(busy), .out_valid_o(out_valid), .out_last_o(out_last),
    .out_re_o(out_re), .out_im_o(out_im)
  );

  int n_chk = 0, n_err = 0;
  int xs_re [N], xs_im [N];
  int ex_re [N], ex_im [N];

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic longint rshr(longint v, int s);
    return (v + (longint'(1) << (s - 1))) >>> s;
  endfunction

  function automatic int rev(int v);
    int r = 0;
    for (int i = 0; i < LOG2N; i++) if (v & (1 << i)) r += 1 << (LOG2N - 1 - i);
    return r;
  endfunction

  // bit-accurate behavioural model of R3, R4, R5, R10
  task automatic model();
    longint ar [N], ai [N];
    for (int i = 0; i < N; i++) begin
      ar[rev(i)] = xs_re[i];
      ai[rev(i)] = xs_im[i];
    end
    for (int s = 0; s < LOG2N; s++) begin
      int half = 1 << s;
      for (int g = 0; g < N; g += 2 * half) begin
        for (int j = 0; j < half; j++) begin
          int t = g + j, u = g + j + half, k = j * (N / (2 * half));
          real ang = 2.0 * 3.141592653589793 * k / N;
          longint wr = int'(32767.0 * $cos(ang));
          longint wi = -int'(32767.0 * $sin(ang));
          longint pr = rshr(ar[u] * wr - ai[u] * wi, 15);
          longint pi = rshr(ar[u] * wi + ai[u] * wr, 15);
          longint hr = ar[t], hi = ai[t];
          ar[t] = sat16(rshr(hr + pr, 1));
          ai[t] = sat16(rshr(hi + pi, 1));
          ar[u] = sat16(rshr(hr - pr, 1));
          ai[u] = sat16(rshr(hi - pi, 1));
        end
      end
    end
    for (int k = 0; k < N; k++) begin
      int d = (k < N - k) ? k : N - k;
      longint hr = 32767 - (2 * 32767 * d) / N;
      longint hi = (k < N / 2) ? -(k * 1024) : (N - k) * 1024;
      ex_re[k] = sat16(rshr(ar[k] * hr - ai[k] * hi, 15));
      ex_im[k] = sat16(rshr(ar[k] * hi + ai[k] * hr, 15));
    end
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  // drives len samples; ends at the negedge after the closing edge
  task automatic send_block(int len, bit hold);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_last = (i == len - 1);
      in_re = 16'(xs_re[i]); in_im = 16'(xs_im[i]);
    end
    @(negedge clk);
    in_valid = hold; in_sop = hold; in_last = 1'b0;
    in_re = 16'sd12345; in_im = -16'sd777;
    for (int i = len; i < N; i++) begin
      xs_re[i] = 0; xs_im[i] = 0;
    end
  endtask

  task automatic expect_block(string tag);
    model();
    for (int c = 0; c < LOG2N; c++) begin
      if (c > 0) @(negedge clk);
      chk("R6", "busy during calc", int'(busy), 1);
      chk("R8", "in_ready during calc", int'(in_ready), 0);
      chk("R6", "out_valid during calc", int'(out_valid), 0);
    end
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      chk("R6", $sformatf("out_valid bin %0d", k), int'(out_valid), 1);
      chk("R7", $sformatf("out_last bin %0d", k), int'(out_last), int'(k == N - 1));
      chk("R8", $sformatf("in_ready bin %0d", k), int'(in_ready), 0);
      chk(tag, $sformatf("Y(%0d).re", k), int'(out_re), ex_re[k]);
      chk(tag, $sformatf("Y(%0d).im", k), int'(out_im), ex_im[k]);
      if (k == N - 1) begin
        in_valid = 1'b0; in_sop = 1'b0;
      end
    end
    @(negedge clk);
    chk("R7", "in_ready after last", int'(in_ready), 1);
    chk("R7", "busy after last", int'(busy), 0);
    chk("R7", "out_valid after last", int'(out_valid), 0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog R6 act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "reset in_ready", int'(in_ready), 1);
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset out_valid", int'(out_valid), 0);

    // R2: samples without a start flag and no open block
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_last = (i == N - 1);
      in_re = 16'(rnd16()); in_im = 16'(rnd16());
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    for (int c = 0; c < N + LOG2N + 2; c++) begin
      @(negedge clk);
      chk("R2", "busy after stray input", int'(busy), 0);
      chk("R2", "out_valid after stray input", int'(out_valid), 0);
    end

    // impulse
    for (int i = 0; i < N; i++) begin xs_re[i] = 0; xs_im[i] = 0; end
    xs_re[0] = 16384;
    send_block(N, 1'b0); expect_block("R5");

    // constant input
    for (int i = 0; i < N; i++) begin xs_re[i] = 8000; xs_im[i] = -3000; end
    send_block(N, 1'b0); expect_block("R4");

    // random blocks
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < N; i++) begin
        xs_re[i] = rnd16() / 4; xs_im[i] = rnd16() / 4;
      end
      send_block(N, 1'b0); expect_block("R4");
    end

    // R3: short block, zero padded
    for (int i = 0; i < N; i++) begin xs_re[i] = rnd16(); xs_im[i] = rnd16(); end
    send_block(5, 1'b0); expect_block("R3");

    // R9: partial block, then restart
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_last = 1'b0;
      in_re = 16'sd30000; in_im = -16'sd30000;
    end
    for (int i = 0; i < N; i++) begin xs_re[i] = rnd16() / 2; xs_im[i] = rnd16() / 2; end
    send_block(N - 4, 1'b0); expect_block("R9");

    // R8: input held valid with start flag during the whole busy time
    for (int i = 0; i < N; i++) begin xs_re[i] = rnd16() / 3; xs_im[i] = rnd16() / 3; end
    send_block(N, 1'b1); expect_block("R8");

    // R10: full-scale extremes force saturation
    for (int i = 0; i < N; i++) begin
      xs_re[i] = (i % 3 == 0) ? 32767 : -32768;
      xs_im[i] = (i % 2 == 1) ? 32767 : -32768;
    end
    send_block(N, 1'b0); expect_block("R10");

    for (int i = 0; i < N; i++) begin
      xs_re[i] = (i % 2 == 0) ? 32767 : -32768;
      xs_im[i] = 32767;
    end
    send_block(N, 1'b0); expect_block("R10");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule